// File: doc/BRIEF.md
# Slot-Port Network Interrupt Aggregator

This block gathers network interrupt requests from a set of module slots, each slot carrying four port lines, and folds them into a single level interrupt toward the processor. Requests arrive as set and clear pulses that name a slot and a port. Each request touches exactly one bit of a 32-bit status register. The slot-to-bit placement is irregular and depends on a static chassis variant input.

Variant A holds one status register and knows slots 0 to 3. Variant B knows slots 0 to 6. In variant B, slot 0 lands in a second register and the other six slots share the first. Software reads the registers back through a small combinational read port. In variant A this port exposes the first register as four byte lanes. In variant B it gives the first register as a whole word and the second as a byte.

Top module: `netirq_agg`

## Requirements
- R1: While rst_n is low and after its release with no request, both status registers are zero, irq_o is low and every rd_sel_i value reads 0.
- R2: With variant_b_i = 0, a set for slot s, port p raises bit (base + p) of the first register, where base is 16, 24, 0 and 8 for slots 0, 1, 2 and 3.
- R3: With variant_b_i = 1, slot 0, port p raises bit p of the second register. Slots 1 to 6 raise bit (base + p) of the first register, with base 24, 16, 28, 20, 8 and 0 in slot order.
- R4: A set changes only its addressed bit; setting an already set bit leaves all state as it was.
- R5: A clear lowers only its addressed bit; clearing an unset bit leaves all state as it was.
- R6: When set and clear address the same bit in one cycle, the bit ends up set. When they address different bits, both take effect.
- R7: Requests naming a slot the variant lacks leave all state unchanged: slots 4 to 7 in variant A, slot 7 in variant B.
- R8: irq_o is high exactly when, one cycle earlier, the first register was nonzero (variant A) or either register was nonzero (variant B). It therefore follows a status change by one clock.
- R9: In variant A, rd_sel_i 0, 1, 2 and 3 return bits 31:24, 23:16, 15:8 and 7:0 of the first register, zero-extended. rd_sel_i 4 to 7 return 0.
- R10: In variant B, rd_sel_i 4 returns the whole first register and rd_sel_i 5 returns the low byte of the second register, zero-extended. All other rd_sel_i values return 0.
- R11: variant_b_i is held static and is changed only while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| variant_b_i | input | 1 | Chassis variant select: 0 = A, 1 = B |
| set_vld_i | input | 1 | Set request strobe |
| set_slot_i | input | 3 | Slot addressed by the set request |
| set_port_i | input | 2 | Port addressed by the set request |
| clr_vld_i | input | 1 | Clear request strobe |
| clr_slot_i | input | 3 | Slot addressed by the clear request |
| clr_port_i | input | 2 | Port addressed by the clear request |
| rd_sel_i | input | 3 | Read selector |
| rd_data_o | output | 32 | Read data, combinational from registered state |
| irq_o | output | 1 | Registered network interrupt level |

## Verification
The assertions check several properties on every cycle:
- Without a set, no new bits appear, and without a clear, no bits are lost.
- At most one bit rises per cycle.
- A coincident set and clear on the same slot and port never lowers a bit.
- A missing slot leaves both registers stable.
- irq_o tracks the nonzero state of the registers with a lag of one cycle.
- The second register stays empty in variant A.

The exact bit placement for each slot and port, and the byte lanes seen at each read selector, cannot be seen by the assertions. The bench shows them by sweeping every slot and port in both variants against its own offset table.

// File: rtl/netirq_pkg.sv
package netirq_pkg;

    localparam int STAT_W = 32;
    localparam int SLOT_W = 3;
    localparam int PORT_W = 2;
    localparam int POS_W  = $clog2(STAT_W);

    typedef struct packed {
        logic             valid;
        logic             hi_reg;
        logic [POS_W-1:0] base;
    } slot_map_t;

    // Placement of a slot's four port bits, per chassis variant.
    function automatic slot_map_t map_slot(input logic var_b, input logic [SLOT_W-1:0] slot);
        slot_map_t m;
        m.valid  = 1'b1;
        m.hi_reg = 1'b0;
        m.base   = '0;
        if (!var_b) begin
            case (slot)
                3'd0:    m.base = POS_W'(16);
                3'd1:    m.base = POS_W'(24);
                3'd2:    m.base = POS_W'(0);
                3'd3:    m.base = POS_W'(8);
                default: m.valid = 1'b0;
            endcase
        end else begin
            case (slot)
                3'd0:    m.hi_reg = 1'b1;
                3'd1:    m.base = POS_W'(24);
                3'd2:    m.base = POS_W'(16);
                3'd3:    m.base = POS_W'(28);
                3'd4:    m.base = POS_W'(20);
                3'd5:    m.base = POS_W'(8);
                3'd6:    m.base = POS_W'(0);
                default: m.valid = 1'b0;
            endcase
        end
        return m;
    endfunction

endpackage

// File: rtl/netirq_decode.sv
module netirq_decode
    import netirq_pkg::*;
#(
    parameter int STW = STAT_W,
    parameter int SW  = SLOT_W,
    parameter int PW  = PORT_W
) (
    input  logic          vld_i,
    input  logic          var_b_i,
    input  logic [SW-1:0] slot_i,
    input  logic [PW-1:0] port_i,
    output logic [STW-1:0] mask_lo_o,
    output logic [STW-1:0] mask_hi_o
);
    localparam int PSW = $clog2(STW);

    slot_map_t        map;
    logic [PSW-1:0]   pos;

    always_comb begin
        map       = map_slot(var_b_i, SLOT_W'(slot_i));
        pos       = PSW'(map.base) + PSW'(port_i);
        mask_lo_o = '0;
        mask_hi_o = '0;
        if (vld_i && map.valid) begin
            if (map.hi_reg) mask_hi_o[pos] = 1'b1;
            else            mask_lo_o[pos] = 1'b1;
        end
    end
endmodule

// File: rtl/netirq_rdmux.sv
module netirq_rdmux #(
    parameter int STW   = 32,
    parameter int SEL_W = 3
) (
    input  logic             var_b_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [STW-1:0]   lo_i,
    input  logic [STW-1:0]   hi_i,
    output logic [STW-1:0]   data_o
);
    localparam int LANES = STW / 8;

    always_comb begin
        data_o = '0;
        if (!var_b_i) begin
            for (int k = 0; k < LANES; k++) begin
                if (int'(sel_i) == k) data_o = STW'(lo_i[STW-1-8*k -: 8]);
            end
        end else begin
            if (int'(sel_i) == LANES)     data_o = lo_i;
            if (int'(sel_i) == LANES + 1) data_o = STW'(hi_i[7:0]);
        end
    end
endmodule

// File: rtl/netirq_agg.sv
module netirq_agg
    import netirq_pkg::*;
#(
    parameter int STW   = STAT_W,
    parameter int SW    = SLOT_W,
    parameter int PW    = PORT_W,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             variant_b_i,
    input  logic             set_vld_i,
    input  logic [SW-1:0]    set_slot_i,
    input  logic [PW-1:0]    set_port_i,
    input  logic             clr_vld_i,
    input  logic [SW-1:0]    clr_slot_i,
    input  logic [PW-1:0]    clr_port_i,
    input  logic [SEL_W-1:0] rd_sel_i,
    output logic [STW-1:0]   rd_data_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [STW-1:0] lo;
        logic [STW-1:0] hi;
        logic           irq;
    } state_t;

    state_t st_d, st_q;

    logic [STW-1:0] set_lo, set_hi, clr_lo, clr_hi;
    logic [STW-1:0] stat_lo, stat_hi;

    netirq_decode #(.STW(STW), .SW(SW), .PW(PW)) u_set_dec (
        .vld_i     (set_vld_i),
        .var_b_i   (variant_b_i),
        .slot_i    (set_slot_i),
        .port_i    (set_port_i),
        .mask_lo_o (set_lo),
        .mask_hi_o (set_hi)
    );

    netirq_decode #(.STW(STW), .SW(SW), .PW(PW)) u_clr_dec (
        .vld_i     (clr_vld_i),
        .var_b_i   (variant_b_i),
        .slot_i    (clr_slot_i),
        .port_i    (clr_port_i),
        .mask_lo_o (clr_lo),
        .mask_hi_o (clr_hi)
    );

    // Next state: clear first, then OR the set so a coincident set wins.
    always_comb begin
        st_d     = st_q;
        st_d.lo  = (st_q.lo & ~clr_lo) | set_lo;
        st_d.hi  = (st_q.hi & ~clr_hi) | set_hi;
        st_d.irq = variant_b_i ? ((|st_q.lo) || (|st_q.hi)) : (|st_q.lo);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_lo = st_q.lo;
    assign stat_hi = st_q.hi;
    assign irq_o   = st_q.irq;

    netirq_rdmux #(.STW(STW), .SEL_W(SEL_W)) u_rdmux (
        .var_b_i (variant_b_i),
        .sel_i   (rd_sel_i),
        .lo_i    (stat_lo),
        .hi_i    (stat_hi),
        .data_o  (rd_data_o)
    );
endmodule

// File: rtl/netirq_agg_chk.sv
module netirq_agg_chk #(
    parameter int STW = 32,
    parameter int SW  = 3,
    parameter int PW  = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           variant_b_i,
    input logic           set_vld_i,
    input logic [SW-1:0]  set_slot_i,
    input logic [PW-1:0]  set_port_i,
    input logic           clr_vld_i,
    input logic [SW-1:0]  clr_slot_i,
    input logic [PW-1:0]  clr_port_i,
    input logic [STW-1:0] stat_lo,
    input logic [STW-1:0] stat_hi,
    input logic           irq_o
);
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_clear: assert (irq_o == 1'b0 && stat_lo == '0 && stat_hi == '0);
        end
    end

    a_r4_no_set_no_new_bits: assert property (@(posedge clk) disable iff (!rst_n)
        !set_vld_i |=> ((stat_lo & ~$past(stat_lo)) == '0 && (stat_hi & ~$past(stat_hi)) == '0));

    a_r4_one_bit_rises: assert property (@(posedge clk) disable iff (!rst_n)
        set_vld_i |=> ($countones({stat_lo & ~$past(stat_lo), stat_hi & ~$past(stat_hi)}) <= 1));

    a_r5_no_clr_no_lost_bits: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_vld_i |=> ((~stat_lo & $past(stat_lo)) == '0 && (~stat_hi & $past(stat_hi)) == '0));

    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vld_i && clr_vld_i && set_slot_i == clr_slot_i && set_port_i == clr_port_i)
        |=> ((~stat_lo & $past(stat_lo)) == '0 && (~stat_hi & $past(stat_hi)) == '0));

    a_r7_missing_slot_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vld_i && !clr_vld_i && set_slot_i == {SW{1'b1}}) |=> ($stable(stat_lo) && $stable(stat_hi)));

    a_r7_hi_empty_in_a: assert property (@(posedge clk) disable iff (!rst_n)
        !variant_b_i |-> stat_hi == '0);

    a_r8_irq_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_lo != '0) |=> irq_o);

    a_r8_irq_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_lo == '0 && stat_hi == '0) |=> !irq_o);
endmodule

bind netirq_agg netirq_agg_chk #(.STW(STW), .SW(SW), .PW(PW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .variant_b_i (variant_b_i),
    .set_vld_i   (set_vld_i),
    .set_slot_i  (set_slot_i),
    .set_port_i  (set_port_i),
    .clr_vld_i   (clr_vld_i),
    .clr_slot_i  (clr_slot_i),
    .clr_port_i  (clr_port_i),
    .stat_lo     (stat_lo),
    .stat_hi     (stat_hi),
    .irq_o       (irq_o)
);

// File: tb/netirq_agg_tb.sv
module netirq_agg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        variant_b_i = 1'b0;
    logic        set_vld_i = 1'b0, clr_vld_i = 1'b0;
    logic [2:0]  set_slot_i = '0, clr_slot_i = '0;
    logic [1:0]  set_port_i = '0, clr_port_i = '0;
    logic [2:0]  rd_sel_i = '0;
    logic [31:0] rd_data_o;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    logic [31:0] m_lo = '0, m_hi = '0;

    always #10 clk = ~clk;

    netirq_agg u_dut (
        .clk(clk), .rst_n(rst_n), .variant_b_i(variant_b_i),
        .set_vld_i(set_vld_i), .set_slot_i(set_slot_i), .set_port_i(set_port_i),
        .clr_vld_i(clr_vld_i), .clr_slot_i(clr_slot_i), .clr_port_i(clr_port_i),
        .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // Bench-side offset table built from R2 and R3.
    task automatic place(input logic vb, input int s, input int p,
                         output bit ok, output bit hi, output int pos);
        ok = 1'b1; hi = 1'b0; pos = 0;
        if (!vb) begin
            case (s)
                0: pos = 16 + p;
                1: pos = 24 + p;
                2: pos = p;
                3: pos = 8 + p;
                default: ok = 1'b0;
            endcase
        end else begin
            case (s)
                0: begin hi = 1'b1; pos = p; end
                1: pos = 24 + p;
                2: pos = 16 + p;
                3: pos = 28 + p;
                4: pos = 20 + p;
                5: pos = 8 + p;
                6: pos = p;
                default: ok = 1'b0;
            endcase
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic vb, input int sel);
        if (!vb && sel < 4)  return (m_lo >> (24 - 8 * sel)) & 32'hFF;
        if (vb && sel == 4)  return m_lo;
        if (vb && sel == 5)  return m_hi & 32'hFF;
        return 32'h0;
    endfunction

    task automatic check_reads(input string req);
        for (int sel = 0; sel < 8; sel++) begin
            rd_sel_i = 3'(sel);
            #1;
            chk(rd_data_o, exp_rd(variant_b_i, sel), req, $sformatf("read sel %0d", sel));
        end
    endtask

    function automatic bit irq_model();
        return variant_b_i ? ((m_lo != 0) || (m_hi != 0)) : (m_lo != 0);
    endfunction

    task automatic op(input bit sv, input int ss, input int sp,
                      input bit cv, input int cs, input int cp, input string req);
        bit ok, hi, prev;
        int pos;
        @(negedge clk);
        set_vld_i = sv; set_slot_i = 3'(ss); set_port_i = 2'(sp);
        clr_vld_i = cv; clr_slot_i = 3'(cs); clr_port_i = 2'(cp);
        prev = irq_model();
        @(negedge clk);
        set_vld_i = 1'b0; clr_vld_i = 1'b0;
        if (cv) begin
            place(variant_b_i, cs, cp, ok, hi, pos);
            if (ok) begin
                if (hi) m_hi[pos] = 1'b0; else m_lo[pos] = 1'b0;
            end
        end
        if (sv) begin
            place(variant_b_i, ss, sp, ok, hi, pos);
            if (ok) begin
                if (hi) m_hi[pos] = 1'b1; else m_lo[pos] = 1'b1;
            end
        end
        check_reads(req);
        chk({31'b0, irq_o}, {31'b0, prev}, "R8", "irq one cycle behind status");
        @(negedge clk);
        chk({31'b0, irq_o}, {31'b0, irq_model()}, "R8", "irq after status change");
    endtask

    task automatic do_reset(input logic vb);
        @(negedge clk);
        rst_n = 1'b0;
        variant_b_i = vb;  // R11: variant changes only under reset
        m_lo = '0; m_hi = '0;
        repeat (3) @(negedge clk);
        chk({31'b0, irq_o}, 32'h0, "R1", "irq during reset");
        check_reads("R1");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({31'b0, irq_o}, 32'h0, "R1", "irq after reset");
        check_reads("R1");
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int vb = 0; vb < 2; vb++) begin
            do_reset(vb[0]);
            // Single-bit sweep over every slot and port (R2, R3, R7, R5)
            for (int s = 0; s < 8; s++) begin
                for (int p = 0; p < 4; p++) begin
                    op(1, s, p, 0, 0, 0, vb ? "R3" : "R2");
                    op(0, 0, 0, 1, s, p, "R5");
                end
            end
            // Fill everything, then drain one by one (R4, R5, R8, R9, R10)
            for (int s = 0; s < 8; s++)
                for (int p = 0; p < 4; p++)
                    op(1, s, p, 0, 0, 0, vb ? "R10" : "R9");
            op(1, 1, 2, 0, 0, 0, "R4");           // re-set of a set bit
            op(1, 7, 1, 0, 0, 0, "R7");           // missing slot with full state
            for (int s = 0; s < 8; s++)
                for (int p = 0; p < 4; p++)
                    op(0, 0, 0, 1, s, p, "R5");
            op(0, 0, 0, 1, 2, 3, "R5");           // clear of an unset bit
            // Coincident requests (R6)
            op(1, 2, 1, 1, 2, 1, "R6");           // same bit, was clear
            op(1, 2, 1, 1, 2, 1, "R6");           // same bit, was set
            op(1, 0, 3, 1, 2, 1, "R6");           // different bits
            op(1, 3, 0, 1, 0, 3, "R6");
            // Missing slots with state present (R7)
            op(1, 7, 0, 0, 0, 0, "R7");
            op(0, 0, 0, 1, 7, 0, "R7");
            op(1, 5, 2, 0, 0, 0, vb ? "R3" : "R7");
            op(1, 4, 0, 0, 0, 0, vb ? "R3" : "R7");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule